// File: doc/BRIEF.md
# Status Condition and Event Register Set

This block gathers the live status signals of an instrument into one reporting point. A vector of condition inputs is watched every clock. Each bit has two programmable masks: a rising mask selects 0-to-1 changes and a falling mask selects 1-to-0 changes. A selected change sets the matching bit of a sticky event register. The event register is ANDed with an enable mask, and the result is ORed down to a single summary line. That line can feed a higher-level status collector.

Software reaches the registers through a flat register port. The port has one write strobe, one read strobe and a 3-bit address, and read data is returned combinationally. Reading the event register returns its contents and clears it in the same access. Three strobes act on different groups of registers:

- The synchronous power-on reset sets up the whole set.
- The preset strobe restores the masks.
- The clear-status strobe empties the event register.

One parameter chooses whether preset opens or closes the enable mask. A second parameter builds a lighter variant with no condition tracking, in which events arrive only as direct pulses.

Top module: `status_regset`

## Requirements
- R1: Register addresses are 0 condition, 1 rising mask, 2 falling mask, 3 event and 4 enable; any other address reads 0. With condition tracking built, address 0 reads the live `cond_i` value in the same cycle, with no latching.
- R2: An event bit sets at the clock edge that ends a cycle in which its condition bit differs from the value it had at the previous edge. A 0-to-1 change sets it when the rising-mask bit is 1, and a 1-to-0 change sets it when the falling-mask bit is 1. A change whose mask bit is 0 sets nothing.
- R3: A set event bit stays set through any number of cycles until a read of address 3, a clear-status strobe or a reset clears it.
- R4: A read of address 3 returns the event contents during the access and leaves the register cleared after that clock edge.
- R5: `summary_o` is 1 exactly when some bit is set in both the event and enable registers. A 0 enable bit keeps its event out of the summary.
- R6: Reading the masks, the enable register or the condition register does not change them. Writes to address 0 or address 3 are ignored.
- R7: Power-on reset leaves the rising mask all ones, the falling mask all zeros and the event and enable registers zero. Condition values present during reset produce no event after it.
- R8: Preset makes the rising mask all ones and the falling mask all zeros. It makes the enable register all ones when `PRESET_ENA_ONES` is 1 and all zeros otherwise. It leaves the event register unchanged.
- R9: Clear-status zeroes the event register and leaves the masks and enable register unchanged.
- R10: An event that sets in the same cycle as a read-clear or a clear-status is held after that edge.
- R11: `evt_pulse_i` bits set event bits directly, one cycle after the pulse, in both variants. With `HAS_COND` = 0, addresses 0, 1 and 2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| preset_i | input | 1 | Preset strobe, one cycle |
| clr_i | input | 1 | Clear-status strobe, one cycle |
| cond_i | input | WIDTH | Live condition inputs |
| evt_pulse_i | input | WIDTH | Direct single-cycle event pulses |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears event on address 3) |
| addr_i | input | 3 | Register address |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Read data for `addr_i`, combinational |
| summary_o | output | 1 | OR of event AND enable |

## Verification
The bench builds two instances side by side.

The first uses the defaults: 16 bits, condition tracking on and preset clearing the enable mask. It exercises edge filtering with mixed rise, fall and masked bits, the sticky and read-to-clear behaviour, and the collisions of a new event with a read or a clear-status. It also checks the separate reach of preset, clear-status and reset.

The second is 8 bits wide with no condition tracking and with preset opening the enable mask. It brings the pulse-only path, the zero reads of the absent registers and the all-ones preset of the enable register within reach.

// File: rtl/stat_pkg.sv
// Shared register-select codes for the status register set.
package stat_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_COND = 3'd0,
        SEL_RISE = 3'd1,
        SEL_FALL = 3'd2,
        SEL_EVT  = 3'd3,
        SEL_ENA  = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/stat_edge_filter.sv
// Condition history and per-bit transition masks.
// Produces a one-cycle hit vector for each masked rising or falling change.
// Assumes reset is synchronous and that cond_i is already synchronous to clk.
// With HAS_COND = 0 no storage is built and all outputs read zero.
module stat_edge_filter #(
    parameter int WIDTH    = 16,
    parameter bit HAS_COND = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preset_i,
    input  logic [WIDTH-1:0] cond_i,
    input  logic             wr_rise_i,
    input  logic             wr_fall_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] cond_o,
    output logic [WIDTH-1:0] rise_mask_o,
    output logic [WIDTH-1:0] fall_mask_o,
    output logic [WIDTH-1:0] hit_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ALL_ZERO = {WIDTH{1'b0}};

    generate
        if (HAS_COND) begin : g_track
            logic [WIDTH-1:0] cond_q;
            logic [WIDTH-1:0] rise_q;
            logic [WIDTH-1:0] fall_q;
            logic [WIDTH-1:0] went_up;
            logic [WIDTH-1:0] went_down;

            // History copy: also loaded during reset so no edge is seen on release.
            always_ff @(posedge clk) begin
                cond_q <= cond_i;
            end

            // Rising mask: reset and preset open it, software writes it.
            always_ff @(posedge clk) begin
                if (!rst_n || preset_i) rise_q <= ALL_ONES;
                else if (wr_rise_i)     rise_q <= wdata_i;
            end

            // Falling mask: reset and preset close it, software writes it.
            always_ff @(posedge clk) begin
                if (!rst_n || preset_i) fall_q <= ALL_ZERO;
                else if (wr_fall_i)     fall_q <= wdata_i;
            end

            // Edge detection against the previous-cycle copy.
            always_comb begin
                went_up   = cond_i & ~cond_q;
                went_down = ~cond_i & cond_q;
                hit_o     = (went_up & rise_q) | (went_down & fall_q);
            end

            assign cond_o      = cond_i;
            assign rise_mask_o = rise_q;
            assign fall_mask_o = fall_q;

            // R8: preset restores both masks.
            p_preset_masks_r8: assert property (@(posedge clk) disable iff (!rst_n)
                preset_i |=> (rise_q == ALL_ONES && fall_q == ALL_ZERO));
            // R6: masks hold when neither preset nor a write touches them.
            p_rise_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (!preset_i && !wr_rise_i) |=> $stable(rise_q));
            p_fall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (!preset_i && !wr_fall_i) |=> $stable(fall_q));
            // R2: an unchanged condition vector never produces a hit.
            p_no_change_no_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (cond_i == cond_q) |-> (hit_o == ALL_ZERO));
        end else begin : g_bare
            logic unused_inputs;
            assign unused_inputs = ^{cond_i, wdata_i, wr_rise_i, wr_fall_i, preset_i, rst_n, clk};
            assign cond_o      = ALL_ZERO;
            assign rise_mask_o = ALL_ZERO;
            assign fall_mask_o = ALL_ZERO;
            assign hit_o       = ALL_ZERO;
        end
    endgenerate
endmodule

// File: rtl/stat_event_latch.sv
// Sticky event register.
// Bits set from the set vector and stay until a clear request.
// A set arriving with a clear wins, so no event is lost at the clear boundary.
// Assumes synchronous active-low reset.
module stat_event_latch #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [WIDTH-1:0] set_i,
    output logic [WIDTH-1:0] event_o
);
    logic [WIDTH-1:0] evt_q;

    // Latch new events; a clear drops only the previously held bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       evt_q <= '0;
        else if (clear_i) evt_q <= set_i;
        else              evt_q <= evt_q | set_i;
    end

    assign event_o = evt_q;

    // R3: held bits survive any cycle without a clear.
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
    // R2/R11: every set request is visible after the edge.
    p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((evt_q & $past(set_i)) == $past(set_i)));
    // R10: after a clear, exactly the colliding new events remain.
    p_clear_keeps_new_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (evt_q == $past(set_i)));
endmodule

// File: rtl/stat_summary.sv
// Enable mask register and summary reduction.
// Reset closes the mask; preset closes or opens it according to PRESET_ENA_ONES.
// Assumes synchronous active-low reset.
module stat_summary #(
    parameter int WIDTH           = 16,
    parameter bit PRESET_ENA_ONES = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preset_i,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [WIDTH-1:0] event_i,
    output logic [WIDTH-1:0] enable_o,
    output logic             summary_o
);
    localparam logic [WIDTH-1:0] PRESET_VAL = {WIDTH{PRESET_ENA_ONES}};

    logic [WIDTH-1:0] ena_q;

    // Enable mask: reset, preset value, or software write.
    always_ff @(posedge clk) begin
        if (!rst_n)        ena_q <= '0;
        else if (preset_i) ena_q <= PRESET_VAL;
        else if (wr_i)     ena_q <= wdata_i;
    end

    // Masked OR reduction to the summary line.
    always_comb begin
        summary_o = |(event_i & ena_q);
    end

    assign enable_o = ena_q;

    // R6: mask holds without preset or write.
    p_enable_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_i && !wr_i) |=> $stable(ena_q));
    // R8: preset loads the parameter-selected value.
    p_preset_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        preset_i |=> (ena_q == PRESET_VAL));
    // R5: a closed mask keeps the summary quiet.
    p_closed_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_q == '0) |-> !summary_o);
endmodule

// File: rtl/stat_regport.sv
// Register access decode.
// Turns one write strobe and one read strobe plus an address into per-register
// write enables, the read-clear request and a combinational read mux.
// Assumes at most one access per cycle.
module stat_regport
    import stat_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WIDTH-1:0]  cond_i,
    input  logic [WIDTH-1:0]  rise_i,
    input  logic [WIDTH-1:0]  fall_i,
    input  logic [WIDTH-1:0]  event_i,
    input  logic [WIDTH-1:0]  enable_i,
    output logic              wr_rise_o,
    output logic              wr_fall_o,
    output logic              wr_ena_o,
    output logic              rd_clr_o,
    output logic [WIDTH-1:0]  rdata_o
);
    reg_sel_e sel;

    assign sel = reg_sel_e'(addr_i);

    // Write and read-clear strobes per register; condition and event are not writable.
    always_comb begin
        wr_rise_o = wr_en_i && (sel == SEL_RISE);
        wr_fall_o = wr_en_i && (sel == SEL_FALL);
        wr_ena_o  = wr_en_i && (sel == SEL_ENA);
        rd_clr_o  = rd_en_i && (sel == SEL_EVT);
    end

    // Read data mux; unmapped addresses return zero.
    always_comb begin
        case (sel)
            SEL_COND: rdata_o = cond_i;
            SEL_RISE: rdata_o = rise_i;
            SEL_FALL: rdata_o = fall_i;
            SEL_EVT:  rdata_o = event_i;
            SEL_ENA:  rdata_o = enable_i;
            default:  rdata_o = '0;
        endcase
    end

    // R6: at most one register write strobe at a time.
    always_comb begin
        a_one_write_r6: assert ($onehot0({wr_rise_o, wr_fall_o, wr_ena_o}));
    end
endmodule

// File: rtl/status_regset.sv
// Instrument status register set.
// Live conditions pass through rise/fall masks into a sticky event register,
// which is gated by an enable mask and reduced to one summary line.
// The strobes act on different groups: reset clears or restores all registers,
// preset restores the masks and the enable value, clear-status empties the events.
// Assumes synchronous active-low reset and inputs synchronous to clk.
module status_regset
    import stat_pkg::*;
#(
    parameter int WIDTH           = 16,
    parameter bit HAS_COND        = 1'b1,
    parameter bit PRESET_ENA_ONES = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preset_i,
    input  logic              clr_i,
    input  logic [WIDTH-1:0]  cond_i,
    input  logic [WIDTH-1:0]  evt_pulse_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WIDTH-1:0]  wdata_i,
    output logic [WIDTH-1:0]  rdata_o,
    output logic              summary_o
);
    logic [WIDTH-1:0] cond_v;
    logic [WIDTH-1:0] rise_v;
    logic [WIDTH-1:0] fall_v;
    logic [WIDTH-1:0] hit_v;
    logic [WIDTH-1:0] evt_v;
    logic [WIDTH-1:0] ena_v;
    logic [WIDTH-1:0] set_v;
    logic             wr_rise;
    logic             wr_fall;
    logic             wr_ena;
    logic             rd_clr;
    logic             evt_clear;

    stat_regport #(.WIDTH(WIDTH)) u_port (
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .addr_i   (addr_i),
        .cond_i   (cond_v),
        .rise_i   (rise_v),
        .fall_i   (fall_v),
        .event_i  (evt_v),
        .enable_i (ena_v),
        .wr_rise_o(wr_rise),
        .wr_fall_o(wr_fall),
        .wr_ena_o (wr_ena),
        .rd_clr_o (rd_clr),
        .rdata_o  (rdata_o)
    );

    stat_edge_filter #(.WIDTH(WIDTH), .HAS_COND(HAS_COND)) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .preset_i   (preset_i),
        .cond_i     (cond_i),
        .wr_rise_i  (wr_rise),
        .wr_fall_i  (wr_fall),
        .wdata_i    (wdata_i),
        .cond_o     (cond_v),
        .rise_mask_o(rise_v),
        .fall_mask_o(fall_v),
        .hit_o      (hit_v)
    );

    // Merge filtered edges with direct pulses; either clear source empties the latch.
    always_comb begin
        set_v     = hit_v | evt_pulse_i;
        evt_clear = rd_clr | clr_i;
    end

    stat_event_latch #(.WIDTH(WIDTH)) u_events (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(evt_clear),
        .set_i  (set_v),
        .event_o(evt_v)
    );

    stat_summary #(.WIDTH(WIDTH), .PRESET_ENA_ONES(PRESET_ENA_ONES)) u_summary (
        .clk      (clk),
        .rst_n    (rst_n),
        .preset_i (preset_i),
        .wr_i     (wr_ena),
        .wdata_i  (wdata_i),
        .event_i  (evt_v),
        .enable_o (ena_v),
        .summary_o(summary_o)
    );

    // R9: clear-status without a colliding set leaves the event register empty.
    p_clear_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_v == '0) |=> (evt_v == '0));
    // R4: a read-clear without a colliding set leaves the event register empty.
    p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && set_v == '0) |=> (evt_v == '0));
endmodule

// File: tb/status_regset_tb.sv
// Directed bench: two instances, one task per scenario.
module status_regset_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_chk = 0;
    int   n_bad = 0;

    always #5 clk = ~clk;

    // Instance A: defaults (16 bits, condition tracking, preset closes enable).
    logic        pre_a = 0, clr_a = 0, wr_a = 0, rd_a = 0;
    logic [15:0] cond_a = 16'h00F0, pls_a = 0, wd_a = 0, rdat_a;
    logic [2:0]  ad_a = 0;
    logic        sum_a;

    status_regset u_dut (
        .clk(clk), .rst_n(rst_n), .preset_i(pre_a), .clr_i(clr_a),
        .cond_i(cond_a), .evt_pulse_i(pls_a), .wr_en_i(wr_a), .rd_en_i(rd_a),
        .addr_i(ad_a), .wdata_i(wd_a), .rdata_o(rdat_a), .summary_o(sum_a)
    );

    // Instance B: 8 bits, pulse-only, preset opens enable.
    logic       pre_b = 0, clr_b = 0, wr_b = 0, rd_b = 0;
    logic [7:0] pls_b = 0, wd_b = 0, rdat_b;
    logic [2:0] ad_b = 0;
    logic       sum_b;

    status_regset #(.WIDTH(8), .HAS_COND(1'b0), .PRESET_ENA_ONES(1'b1)) u_dut2 (
        .clk(clk), .rst_n(rst_n), .preset_i(pre_b), .clr_i(clr_b),
        .cond_i(8'h00), .evt_pulse_i(pls_b), .wr_en_i(wr_b), .rd_en_i(rd_b),
        .addr_i(ad_b), .wdata_i(wd_b), .rdata_o(rdat_b), .summary_o(sum_b)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr_reg_a(input logic [2:0] a, input logic [15:0] d);
        ad_a = a; wd_a = d; wr_a = 1; step(); wr_a = 0;
    endtask

    task automatic rd_reg_a(input logic [2:0] a, output logic [15:0] d);
        ad_a = a; rd_a = 1; #1 d = rdat_a; step(); rd_a = 0;
    endtask

    task automatic rd_reg_b(input logic [2:0] a, output logic [15:0] d);
        ad_b = a; rd_b = 1; #1 d = {8'h00, rdat_b}; step(); rd_b = 0;
    endtask

    task automatic t_reset_state();
        logic [15:0] d;
        rd_reg_a(3'd1, d); check("R7 rise mask after reset", d, 16'hFFFF);
        rd_reg_a(3'd2, d); check("R7 fall mask after reset", d, 16'h0000);
        rd_reg_a(3'd4, d); check("R7 enable after reset", d, 16'h0000);
        rd_reg_a(3'd3, d); check("R7 no event after reset", d, 16'h0000);
        check("R7 summary after reset", {15'd0, sum_a}, 16'h0000);
    endtask

    task automatic t_live_condition();
        logic [15:0] d;
        cond_a = 16'h1234; ad_a = 3'd0; #1;
        check("R1 condition live", rdat_a, 16'h1234);
        ad_a = 3'd6; #1;
        check("R1 unmapped reads zero", rdat_a, 16'h0000);
        step();
        rd_reg_a(3'd0, d); check("R1 condition read", d, 16'h1234);
    endtask

    task automatic t_edge_filter();
        logic [15:0] d;
        wr_reg_a(3'd1, 16'h0003);
        wr_reg_a(3'd2, 16'h0030);
        cond_a = 16'h0030; step();
        clr_a = 1; step(); clr_a = 0;
        cond_a = 16'h000F; step();
        wr_reg_a(3'd4, 16'h0001);
        check("R5 summary with enabled event", {15'd0, sum_a}, 16'h0001);
        cond_a = 16'h0030; step(); step(); step();
        wr_reg_a(3'd4, 16'h0100);
        check("R5 summary masked", {15'd0, sum_a}, 16'h0000);
        rd_reg_a(3'd3, d); check("R2 R3 masked edges latched and held", d, 16'h0033);
        rd_reg_a(3'd3, d); check("R4 event cleared by read", d, 16'h0000);
    endtask

    task automatic t_read_side_effects();
        logic [15:0] d;
        rd_reg_a(3'd1, d); rd_reg_a(3'd1, d); check("R6 rise mask kept by reads", d, 16'h0003);
        rd_reg_a(3'd2, d); check("R6 fall mask kept", d, 16'h0030);
        rd_reg_a(3'd4, d); rd_reg_a(3'd4, d); check("R6 enable kept by reads", d, 16'h0100);
        wr_reg_a(3'd0, 16'hFFFF);
        wr_reg_a(3'd3, 16'hFFFF);
        rd_reg_a(3'd3, d); check("R6 event write ignored", d, 16'h0000);
        rd_reg_a(3'd0, d); check("R6 condition write ignored", d, 16'h0030);
    endtask

    task automatic t_collisions();
        logic [15:0] d;
        cond_a = 16'h0031; step();
        cond_a = 16'h0033; ad_a = 3'd3; rd_a = 1; #1;
        check("R4 read returns held event", rdat_a, 16'h0001);
        step(); rd_a = 0;
        rd_reg_a(3'd3, d); check("R10 event kept across read-clear", d, 16'h0002);
        cond_a = 16'h0010; clr_a = 1; step(); clr_a = 0;
        rd_reg_a(3'd3, d); check("R10 event kept across clear-status", d, 16'h0020);
    endtask

    task automatic t_clear_status();
        logic [15:0] d;
        cond_a = 16'h0011; step();
        wr_reg_a(3'd4, 16'h0001);
        check("R5 summary raised", {15'd0, sum_a}, 16'h0001);
        clr_a = 1; step(); clr_a = 0;
        check("R9 summary after clear-status", {15'd0, sum_a}, 16'h0000);
        rd_reg_a(3'd4, d); check("R9 enable kept", d, 16'h0001);
        rd_reg_a(3'd1, d); check("R9 rise mask kept", d, 16'h0003);
        rd_reg_a(3'd2, d); check("R9 fall mask kept", d, 16'h0030);
        rd_reg_a(3'd3, d); check("R9 events cleared", d, 16'h0000);
    endtask

    task automatic t_preset();
        logic [15:0] d;
        cond_a = 16'h0010; step();
        cond_a = 16'h0011; step();
        pre_a = 1; step(); pre_a = 0;
        rd_reg_a(3'd1, d); check("R8 rise mask preset", d, 16'hFFFF);
        rd_reg_a(3'd2, d); check("R8 fall mask preset", d, 16'h0000);
        rd_reg_a(3'd4, d); check("R8 enable closed by preset", d, 16'h0000);
        rd_reg_a(3'd3, d); check("R8 event kept by preset", d, 16'h0001);
    endtask

    task automatic t_power_on();
        logic [15:0] d;
        cond_a = 16'h0013; step();
        wr_reg_a(3'd4, 16'h00FF);
        wr_reg_a(3'd2, 16'h00FF);
        rst_n = 0; cond_a = 16'h0F00; step(); step(); rst_n = 1; step();
        rd_reg_a(3'd4, d); check("R7 enable cleared by reset", d, 16'h0000);
        rd_reg_a(3'd2, d); check("R7 fall mask cleared by reset", d, 16'h0000);
        rd_reg_a(3'd3, d); check("R7 events cleared, no false edge", d, 16'h0000);
    endtask

    task automatic t_pulse_variant();
        logic [15:0] d;
        pls_a = 16'h8000; pls_b = 8'h05; step(); pls_a = 0; pls_b = 0;
        rd_reg_a(3'd3, d); check("R11 pulse sets event (tracked)", d, 16'h8000);
        check("R5 variant summary closed", {15'd0, sum_b}, 16'h0000);
        pre_b = 1; step(); pre_b = 0;
        check("R8 variant summary after preset", {15'd0, sum_b}, 16'h0001);
        rd_reg_b(3'd4, d); check("R8 variant enable opened", d, 16'h00FF);
        rd_reg_b(3'd0, d); check("R11 variant condition zero", d, 16'h0000);
        rd_reg_b(3'd1, d); check("R11 variant rise mask zero", d, 16'h0000);
        rd_reg_b(3'd2, d); check("R11 variant fall mask zero", d, 16'h0000);
        rd_reg_b(3'd3, d); check("R11 variant pulse event", d, 16'h0005);
        check("R4 variant summary after read", {15'd0, sum_b}, 16'h0000);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        step();
        t_reset_state();
        t_live_condition();
        t_edge_filter();
        t_read_side_effects();
        t_collisions();
        t_clear_status();
        t_preset();
        t_power_on();
        t_pulse_variant();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule